// File: doc/BRIEF.md
# Error Status Log and Interrupt Unit

This block gathers the memory error events of one DMA channel into a status register that software clears by writing ones. It turns those status bits into two interrupt lines through a mask, and into a fatal indication that disables the channel. The error detectors sit elsewhere. They hand this block single-cycle pulses that carry the failing address and, for ECC errors, the syndrome.

Each error source has a log that keeps the address (and syndrome) of the first error only. A log stays locked until software writes 1 to the matching status bit, which empties the log and re-arms it. A stateless debug register lets software set status bits as if the hardware had raised them. All registers are reached through a simple port: a write strobe, a 3-bit register index, write data, and read data that is valid in the same cycle.

Top module: `err_log_irq`

## Requirements
- R1: Status register at index 0 holds four bits: bit 0 reorder-buffer single-bit ECC error, bit 1 reorder-buffer double-bit ECC error, bit 2 reorder-table parity error, bit 3 prefetch-buffer parity error. An event pulse sets its bit on the next clock edge.
- R2: Writing index 0 clears every status bit written as 1. Bits written as 0 keep their value.
- R3: Both ECC events share one log at index 3: bit 31 valid, bits 27:16 address, bits 7:0 syndrome. Only the first ECC error after the log empties is captured.
- R4: The table parity log at index 4 (bit 31 valid, bits 7:0 address) captures only the first table parity error.
- R5: The prefetch parity log at index 5 (bit 31 valid, bits 5:0 address) captures only the first prefetch parity error. That error is not fatal.
- R6: Writing 1 to a status bit empties its log (all zero) and re-arms it. Writing 1 to either ECC bit empties the shared ECC log.
- R7: When an event and a write-1 clear of the same bit fall in one cycle, the bit stays set and the log captures the new error.
- R8: The mask register at index 1 resets to 4'hF. A mask bit of 1 keeps its status bit off the interrupts.
- R9: irq_lvl0 is the OR over group 0 (bit 0) of status AND NOT mask. irq_lvl1 is the same OR over group 1 (bits 1 to 3).
- R10: fatal is high while status bit 1 or bit 2 is set, whatever the mask. It falls only after both bits are cleared.
- R11: Writing index 2 sets the status bits written as 1 and leaves the logs alone. Reading index 2 returns the status. The register keeps nothing of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_sbe | input | 1 | Single-bit ECC error pulse |
| ecc_dbe | input | 1 | Double-bit ECC error pulse |
| ecc_addr | input | 12 | Address of the ECC error |
| ecc_syn | input | 8 | Syndrome of the ECC error |
| tbl_perr | input | 1 | Table parity error pulse |
| tbl_addr | input | 8 | Address of the table parity error |
| pref_perr | input | 1 | Prefetch parity error pulse |
| pref_addr | input | 6 | Address of the prefetch parity error |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_lvl0 | output | 1 | Level-0 interrupt |
| irq_lvl1 | output | 1 | Level-1 interrupt |
| fatal | output | 1 | Fatal error, disables the channel |

## Verification
The interrupt and fatal outputs are swept over all 16 mask values crossed with all 16 status values, each status injected through the debug register. This separates the group membership of each bit, the mask polarity and the fatal subset. Directed error sequences send a second error into a locked log to show that the first is kept. They clear one ECC bit to show that the shared log empties, and clear a bit in the same cycle as a new event to settle which one wins. A write of zeros and a debug write with no address show that neither disturbs the other state.

// File: rtl/err_log_irq.sv
module err_log_irq #(
  parameter int ECC_AW  = 12,
  parameter int SYN_W   = 8,
  parameter int TBL_AW  = 8,
  parameter int PREF_AW = 6,
  parameter int RW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ecc_sbe,
  input  logic               ecc_dbe,
  input  logic [ECC_AW-1:0]  ecc_addr,
  input  logic [SYN_W-1:0]   ecc_syn,
  input  logic               tbl_perr,
  input  logic [TBL_AW-1:0]  tbl_addr,
  input  logic               pref_perr,
  input  logic [PREF_AW-1:0] pref_addr,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [RW-1:0]      reg_wdata,
  output logic [RW-1:0]      reg_rdata,
  output logic               irq_lvl0,
  output logic               irq_lvl1,
  output logic               fatal
);
  localparam int NB = 4;
  localparam logic [NB-1:0] GRP0  = 4'b0001;
  localparam logic [NB-1:0] GRP1  = 4'b1110;
  localparam logic [NB-1:0] FATAL = 4'b0110;
  localparam logic [2:0] A_STAT = 3'd0, A_MASK = 3'd1, A_DBG = 3'd2,
                         A_ECC = 3'd3, A_TBL = 3'd4, A_PREF = 3'd5;
  localparam int ECC_SH = 16;

  logic [NB-1:0]      stat, mask;
  logic               ecc_v, tbl_v, pref_v;
  logic [ECC_AW-1:0]  ecc_a;
  logic [SYN_W-1:0]   ecc_s;
  logic [TBL_AW-1:0]  tbl_a;
  logic [PREF_AW-1:0] pref_a;

  wire [NB-1:0] evt = {pref_perr, tbl_perr, ecc_dbe, ecc_sbe};
  wire [NB-1:0] clr = (reg_we && reg_addr == A_STAT) ? reg_wdata[NB-1:0] : '0;
  wire [NB-1:0] inj = (reg_we && reg_addr == A_DBG)  ? reg_wdata[NB-1:0] : '0;

  wire ecc_clr  = |clr[1:0];
  wire ecc_take = (ecc_sbe | ecc_dbe) && (!ecc_v || ecc_clr);
  wire tbl_take = tbl_perr && (!tbl_v || clr[2]);
  wire pref_take = pref_perr && (!pref_v || clr[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '1;
    end else begin
      stat <= (stat & ~clr) | evt | inj;
      if (reg_we && reg_addr == A_MASK) mask <= reg_wdata[NB-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecc_v <= 1'b0; ecc_a <= '0; ecc_s <= '0;
    end else if (ecc_take) begin
      ecc_v <= 1'b1; ecc_a <= ecc_addr; ecc_s <= ecc_syn;
    end else if (ecc_clr) begin
      ecc_v <= 1'b0; ecc_a <= '0; ecc_s <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_v <= 1'b0; tbl_a <= '0;
    end else if (tbl_take) begin
      tbl_v <= 1'b1; tbl_a <= tbl_addr;
    end else if (clr[2]) begin
      tbl_v <= 1'b0; tbl_a <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pref_v <= 1'b0; pref_a <= '0;
    end else if (pref_take) begin
      pref_v <= 1'b1; pref_a <= pref_addr;
    end else if (clr[3]) begin
      pref_v <= 1'b0; pref_a <= '0;
    end
  end

  wire [NB-1:0] live = stat & ~mask;
  assign irq_lvl0 = |(live & GRP0);
  assign irq_lvl1 = |(live & GRP1);
  assign fatal    = |(stat & FATAL);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT, A_DBG: reg_rdata[NB-1:0] = stat;
      A_MASK:        reg_rdata[NB-1:0] = mask;
      A_ECC: begin
        reg_rdata[RW-1] = ecc_v;
        reg_rdata[ECC_SH +: ECC_AW] = ecc_a;
        reg_rdata[0 +: SYN_W] = ecc_s;
      end
      A_TBL: begin
        reg_rdata[RW-1] = tbl_v;
        reg_rdata[0 +: TBL_AW] = tbl_a;
      end
      A_PREF: begin
        reg_rdata[RW-1] = pref_v;
        reg_rdata[0 +: PREF_AW] = pref_a;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/err_log_irq_chk.sv
module err_log_irq_chk #(
  parameter int ECC_AW = 12,
  parameter int SYN_W  = 8,
  parameter int RW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ecc_sbe,
  input logic              ecc_dbe,
  input logic              tbl_perr,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [RW-1:0]     reg_wdata,
  input logic [3:0]        stat,
  input logic [3:0]        mask,
  input logic              ecc_v,
  input logic [ECC_AW-1:0] ecc_a,
  input logic [SYN_W-1:0]  ecc_s,
  input logic              irq_lvl0,
  input logic              fatal
);
  // R1
  sbe_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_sbe |=> stat[0]);

  // R2
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && reg_wdata[2] && !tbl_perr) |=> !stat[2]);

  // R2
  w0_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && reg_wdata[3:0] == 4'd0) |=> (stat & $past(stat)) == $past(stat));

  // R3
  ecc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_v && !(reg_we && reg_addr == 3'd0 && |reg_wdata[1:0])) |=> ($stable(ecc_a) && $stable(ecc_s) && ecc_v));

  // R7
  clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_dbe && reg_we && reg_addr == 3'd0 && reg_wdata[1]) |=> (stat[1] && ecc_v));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask[0] |-> !irq_lvl0);

  // R10
  dbe_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_dbe |=> fatal);
endmodule

bind err_log_irq err_log_irq_chk #(.ECC_AW(ECC_AW), .SYN_W(SYN_W), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ecc_sbe(ecc_sbe), .ecc_dbe(ecc_dbe),
  .tbl_perr(tbl_perr), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .stat(stat), .mask(mask), .ecc_v(ecc_v),
  .ecc_a(ecc_a), .ecc_s(ecc_s), .irq_lvl0(irq_lvl0), .fatal(fatal)
);

// File: tb/sim_err_log_irq.sv
module sim_err_log_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ecc_sbe = 0, ecc_dbe = 0, tbl_perr = 0, pref_perr = 0, reg_we = 0;
  logic [11:0] ecc_addr = '0;
  logic [7:0]  ecc_syn = '0, tbl_addr = '0;
  logic [5:0]  pref_addr = '0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_lvl0, irq_lvl1, fatal;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  err_log_irq u0 (.clk(clk), .rst_n(rst_n), .ecc_sbe(ecc_sbe), .ecc_dbe(ecc_dbe),
    .ecc_addr(ecc_addr), .ecc_syn(ecc_syn), .tbl_perr(tbl_perr), .tbl_addr(tbl_addr),
    .pref_perr(pref_perr), .pref_addr(pref_addr), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lvl0(irq_lvl0),
    .irq_lvl1(irq_lvl1), .fatal(fatal));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rdchk(string req, logic [2:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(logic s, logic d, logic t, logic p,
                       logic [11:0] ea, logic [7:0] es, logic [7:0] ta, logic [5:0] pa);
    @(negedge clk);
    ecc_sbe = s; ecc_dbe = d; tbl_perr = t; pref_perr = p;
    ecc_addr = ea; ecc_syn = es; tbl_addr = ta; pref_addr = pa;
    @(negedge clk);
    ecc_sbe = 0; ecc_dbe = 0; tbl_perr = 0; pref_perr = 0;
  endtask

  function automatic logic [31:0] ecc_word(logic [11:0] a, logic [7:0] s);
    return {1'b1, 3'b0, a, 8'b0, s};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 R8 reset state
    rdchk("R1 reset status", 3'd0, 32'h0);
    rdchk("R8 reset mask", 3'd1, 32'hF);
    rdchk("R3 reset ecc log", 3'd3, 32'h0);
    rdchk("R4 reset tbl log", 3'd4, 32'h0);
    rdchk("R5 reset pref log", 3'd5, 32'h0);
    chk("R9 reset irqs", {irq_lvl0, irq_lvl1, fatal}, 32'h0);

    // R1 R3 first ECC error
    pulse(1, 0, 0, 0, 12'hABC, 8'h5A, 8'h0, 6'h0);
    rdchk("R1 sbe status", 3'd0, 32'h1);
    rdchk("R3 ecc log first", 3'd3, ecc_word(12'hABC, 8'h5A));
    chk("R8 masked irq0", irq_lvl0, 1'b0);
    // R3 second error ignored by log
    pulse(0, 1, 0, 0, 12'h123, 8'h33, 8'h0, 6'h0);
    rdchk("R1 dbe status", 3'd0, 32'h3);
    rdchk("R3 ecc log locked", 3'd3, ecc_word(12'hABC, 8'h5A));
    chk("R10 fatal on dbe", fatal, 1'b1);
    chk("R8 masked irq1", irq_lvl1, 1'b0);
    // R2 write zero
    wr(3'd0, 32'h0);
    rdchk("R2 write0 keeps", 3'd0, 32'h3);
    // R6 clear dbe empties shared log
    wr(3'd0, 32'h2);
    rdchk("R2 w1c dbe", 3'd0, 32'h1);
    rdchk("R6 ecc log emptied", 3'd3, 32'h0);
    chk("R10 fatal cleared", fatal, 1'b0);
    pulse(1, 0, 0, 0, 12'h456, 8'h11, 8'h0, 6'h0);
    rdchk("R6 ecc log rearmed", 3'd3, ecc_word(12'h456, 8'h11));

    // R7 event and clear same cycle
    @(negedge clk);
    ecc_dbe = 1; ecc_addr = 12'h789; ecc_syn = 8'hC3;
    reg_we = 1; reg_addr = 3'd0; reg_wdata = 32'h3;
    @(negedge clk);
    ecc_dbe = 0; reg_we = 0; reg_wdata = '0;
    rdchk("R7 clash status", 3'd0, 32'h2);
    rdchk("R7 clash log", 3'd3, ecc_word(12'h789, 8'hC3));

    // R4 table parity log
    pulse(0, 0, 1, 0, 12'h0, 8'h0, 8'h7E, 6'h0);
    pulse(0, 0, 1, 0, 12'h0, 8'h0, 8'h01, 6'h0);
    rdchk("R4 tbl log first", 3'd4, {1'b1, 23'b0, 8'h7E});
    rdchk("R1 tbl status", 3'd0, 32'h6);
    wr(3'd0, 32'h4);
    rdchk("R6 tbl log emptied", 3'd4, 32'h0);
    chk("R10 fatal holds with bit1", fatal, 1'b1);
    wr(3'd0, 32'h2);
    chk("R10 fatal drops", fatal, 1'b0);

    // R5 prefetch parity log, non-fatal
    pulse(0, 0, 0, 1, 12'h0, 8'h0, 8'h0, 6'h2A);
    pulse(0, 0, 0, 1, 12'h0, 8'h0, 8'h0, 6'h15);
    rdchk("R5 pref log first", 3'd5, {1'b1, 25'b0, 6'h2A});
    chk("R5 pref not fatal", fatal, 1'b0);
    wr(3'd0, 32'h8);
    rdchk("R6 pref log emptied", 3'd5, 32'h0);

    // R11 debug injection
    wr(3'd0, 32'hF);
    wr(3'd2, 32'h5);
    rdchk("R11 debug reads status", 3'd2, 32'h5);
    rdchk("R11 status set by debug", 3'd0, 32'h5);
    rdchk("R11 ecc log untouched", 3'd3, 32'h0);
    rdchk("R11 tbl log untouched", 3'd4, 32'h0);
    wr(3'd2, 32'h0);
    rdchk("R11 debug zero no effect", 3'd0, 32'h5);

    // R9 R8 R10 sweep
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 16; s++) begin
        wr(3'd0, 32'hF);
        wr(3'd1, m);
        wr(3'd2, s);
        @(negedge clk);
        chk("R9 irq_lvl0", irq_lvl0, |(s & ~m & 1));
        chk("R9 irq_lvl1", irq_lvl1, |(s & ~m & 14));
        chk("R10 fatal", fatal, |(s & 6));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule